// File: doc/BRIEF.md
# Rail Soft-Start and Fault Supervisor

This block supervises one output rail of a switching regulator. It watches two supply-level flags, an enable input and three digital comparator flags: output too high, output too low, and output inside its regulation window. From these it sequences power-up, ramps a current-limit scale code through four levels while the rail starts, and latches over-voltage or under-voltage faults. It also drives a power-good indication. All timing (the length of each soft-start step, the fault and window deglitch time, and the blanking of under-voltage detection after turn-on) is counted in clock cycles set by parameters.

A latched fault sets the power stage into a safe state. After an over-voltage fault the low-side switch is held on. After an under-voltage fault both switches are released to a high-impedance state. The fault stays latched until the enable input or the supply-above-POR flag goes low. When either input returns high, soft-start begins again from its lowest code.

Top module: `rail_supervisor`

## Requirements
- R1: During reset, and in any cycle after a clock edge at which `supply_por_i` was low, all outputs are 0: `ilim_scale_o`=0, `force_low_o`=0, `tristate_o`=0, `pgood_o`=0. A low `supply_por_i` also clears any latched fault.
- R2: While `supply_por_i`=1 and `supply_uvlo_i`=0, with no under-voltage fault latched, `force_low_o`=1. Soft-start does not begin.
- R3: The channel is active once `supply_por_i`, `supply_uvlo_i` and `enable_i` are all sampled high. The code is `ilim_scale_o`=0 at the first active edge, E0 (0=25%, 1=50%, 2=75%, 3=100% of the current limit). The code rises by one every STEP_CYC edges: 1 at E0+STEP_CYC and 3 at E0+3*STEP_CYC. Soft-start is complete at E0+4*STEP_CYC.
- R4: If `supply_uvlo_i` falls while the channel is active and no fault is latched, the channel stops. `force_low_o` goes to 1 and the code goes to 0. When the flag returns, soft-start restarts from code 0.
- R5: If `ov_flag_i` is high at DEG_CYC consecutive edges while the channel is active, an over-voltage fault latches at the next edge. Then `force_low_o`=1, `tristate_o`=0, the code is 0 and `pgood_o`=0. A pulse that is shorter than DEG_CYC edges has no effect.
- R6: If `uv_flag_i` is high at DEG_CYC consecutive edges while the channel is active and past its blanking time, an under-voltage fault latches at the next edge. Then `tristate_o`=1, `force_low_o`=0, the code is 0 and `pgood_o`=0.
- R7: Under-voltage detection ignores `uv_flag_i` for the first BLANK_CYC edges after E0. A flag held from E0 onward latches at E0+BLANK_CYC+DEG_CYC+1 and not before.
- R8: A latched fault persists after its flag clears and while `supply_uvlo_i` toggles. It clears only when `enable_i` or `supply_por_i` goes low. Raising the input again restarts soft-start at code 0.
- R9: If the over-voltage and under-voltage conditions qualify at the same edge, the over-voltage fault is the one latched.
- R10: `pgood_o` stays 0 throughout soft-start. It rises DEG_CYC+1 edges after soft-start completes, provided `in_window_i` is held high.
- R11: `pgood_o` falls one edge after `in_window_i` has been low at DEG_CYC consecutive edges. Shorter excursions leave it high. It rises again one edge after the window flag has been high at DEG_CYC consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_por_i | input | 1 | Supply above power-on-reset level |
| supply_uvlo_i | input | 1 | Supply above undervoltage-lockout level |
| enable_i | input | 1 | Channel enable |
| ov_flag_i | input | 1 | Output above over-voltage threshold |
| uv_flag_i | input | 1 | Output below under-voltage threshold |
| in_window_i | input | 1 | Output inside the power-good window |
| ilim_scale_o | output | 2 | Current-limit scale code (0..3 = 25%..100%) |
| force_low_o | output | 1 | Request to hold the low-side switch on |
| tristate_o | output | 1 | Request to release both switches |
| pgood_o | output | 1 | Power good (1 = released high) |

## Verification
The bench samples on both sides of every cycle-count boundary. It probes the last edge before each soft-start step, each deglitch qualification and the end of the blanking window, and then the first edge after. A counter off by one at any of these points therefore shows up as a failure. Pulses one edge shorter than the deglitch time must leave the state unchanged, and window excursions that are too short must not drop power good. A design that lacks the filter would latch or drop early. The bench also checks that a latched fault holds while the lockout flag toggles, so a design that cleared faults on that flag would fail. A simultaneous over- and under-voltage case checks that the low-side-on state wins, and a lockout drop in mid-ramp checks that soft-start restarts at code 0 rather than resuming.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_ACT = 2'd1,
    ST_OVL = 2'd2,
    ST_UVL = 2'd3
  } sup_state_e;

  localparam int unsigned NUM_STEPS = 4;
  localparam logic [1:0]  FULL_CODE = 2'(NUM_STEPS - 1);

  localparam int unsigned FLT_OV   = 0;
  localparam int unsigned FLT_UV   = 1;
  localparam int unsigned WIN_OUT  = 2;
  localparam int unsigned WIN_IN   = 3;
  localparam int unsigned NUM_FILT = 4;

  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  function automatic logic pg_next(input logic cur, input logic settled,
                                   input logic out_q, input logic in_q);
    if (!settled)  return 1'b0;
    if (out_q)     return 1'b0;
    if (in_q)      return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/sup_deglitch.sv
module sup_deglitch #(
  parameter int unsigned DEG_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic qual_o
);
  import sup_pkg::*;

  localparam int unsigned CW = cnt_width(DEG_CYC);
  localparam logic [CW-1:0] LIM = CW'(DEG_CYC);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_cnt <= '0;
    else if (!in_i)       run_cnt <= '0;
    else if (run_cnt != LIM) run_cnt <= run_cnt + 1'b1;
  end

  assign qual_o = (run_cnt == LIM);

  // R5
  qual_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_o) |-> $past(in_i));

endmodule

// File: rtl/sup_softstart.sv
module sup_softstart #(
  parameter int unsigned STEP_CYC  = 50000,
  parameter int unsigned BLANK_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  output logic [1:0] code_o,
  output logic       done_o,
  output logic       blank_done_o
);
  import sup_pkg::*;

  localparam int unsigned SW = cnt_width(STEP_CYC);
  localparam int unsigned BW = cnt_width(BLANK_CYC);
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);
  localparam logic [BW-1:0] BLANK_LIM = BW'(BLANK_CYC);

  logic [SW-1:0] step_cnt;
  logic [1:0]    step_idx;
  logic          ss_done;
  logic [BW-1:0] blank_cnt;
  logic          step_wrap;

  assign step_wrap = (step_cnt == STEP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_cnt <= '0;
      step_idx <= '0;
      ss_done  <= 1'b0;
    end else if (!run_i) begin
      step_cnt <= '0;
      step_idx <= '0;
      ss_done  <= 1'b0;
    end else if (!ss_done) begin
      if (step_wrap) begin
        step_cnt <= '0;
        if (step_idx == FULL_CODE) ss_done <= 1'b1;
        else                       step_idx <= step_idx + 2'd1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    blank_cnt <= '0;
    else if (!run_i)               blank_cnt <= '0;
    else if (blank_cnt != BLANK_LIM) blank_cnt <= blank_cnt + 1'b1;
  end

  assign code_o       = step_idx;
  assign done_o       = ss_done;
  assign blank_done_o = (blank_cnt == BLANK_LIM);

  // R3
  code_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i)) |-> (code_o == $past(code_o) || code_o == $past(code_o) + 2'd1));

  // R3
  done_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(step_wrap));

endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
  parameter int unsigned STEP_CYC  = 50000,
  parameter int unsigned DEG_CYC   = 250,
  parameter int unsigned BLANK_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_por_i,
  input  logic       supply_uvlo_i,
  input  logic       enable_i,
  input  logic       ov_flag_i,
  input  logic       uv_flag_i,
  input  logic       in_window_i,
  output logic [1:0] ilim_scale_o,
  output logic       force_low_o,
  output logic       tristate_o,
  output logic       pgood_o
);
  import sup_pkg::*;

  sup_state_e state_q, state_d;
  logic run;
  logic ss_code_n;
  logic [1:0] ss_code;
  logic ss_done, blank_done;
  logic [NUM_FILT-1:0] flt_in, flt_q;
  logic pg_q;

  assign run       = (state_q == ST_ACT);
  assign ss_code_n = 1'b0;

  sup_softstart #(.STEP_CYC(STEP_CYC), .BLANK_CYC(BLANK_CYC)) u_ss (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run),
    .code_o       (ss_code),
    .done_o       (ss_done),
    .blank_done_o (blank_done)
  );

  always_comb begin
    flt_in          = '0;
    flt_in[FLT_OV]  = ov_flag_i & run;
    flt_in[FLT_UV]  = uv_flag_i & run & blank_done;
    flt_in[WIN_OUT] = ~in_window_i & run & ss_done;
    flt_in[WIN_IN]  = in_window_i & run & ss_done;
  end

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_flt
    sup_deglitch #(.DEG_CYC(DEG_CYC)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_i   (flt_in[g]),
      .qual_o (flt_q[g])
    );
  end

  always_comb begin
    state_d = state_q;
    if (!supply_por_i || !enable_i) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF: if (supply_uvlo_i) state_d = ST_ACT;
        ST_ACT: begin
          if (flt_q[FLT_OV])      state_d = ST_OVL;
          else if (flt_q[FLT_UV]) state_d = ST_UVL;
          else if (!supply_uvlo_i) state_d = ST_OFF;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pg_next(pg_q, run & ss_done, flt_q[WIN_OUT], flt_q[WIN_IN]);
  end

  assign ilim_scale_o = run ? ss_code : {1'b0, ss_code_n};
  assign tristate_o   = (state_q == ST_UVL);
  assign force_low_o  = (state_q == ST_OVL) ||
                        ((state_q != ST_UVL) && supply_por_i && !supply_uvlo_i);
  assign pgood_o      = pg_q & run;

  // R1
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_low_o && tristate_o));

  // R8
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_por_i || !enable_i) |=> (!tristate_o && state_q != ST_OVL));

  // R5
  ov_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OVL && supply_por_i && enable_i) |=> force_low_o);

  // R9
  ov_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q[FLT_OV] && run && supply_por_i && enable_i) |=> (force_low_o && !tristate_o));

  // R6
  uv_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tristate_o) |-> $past(flt_q[FLT_UV]));

  // R10
  pgood_full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_o |-> (ilim_scale_o == FULL_CODE));

endmodule

// File: tb/rail_supervisor_bench.sv
module rail_supervisor_bench;

  localparam int unsigned STEP  = 20;
  localparam int unsigned DEG   = 5;
  localparam int unsigned BLANK = 100;

  // {por,uvlo,en,ov,uv,win}[22:17], edges[16:9], {scale,force,tri,pg}[8:4], req[3:0]
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {6'b000000, 8'd2,  5'b00000, 4'd1 },  // R1 supply down
    {6'b101000, 8'd3,  5'b00100, 4'd2 },  // R2 lockout forces low side
    {6'b111001, 8'd1,  5'b00000, 4'd3 },  // R3 E0 code 0
    {6'b111001, 8'd19, 5'b00000, 4'd3 },  // R3 last edge of step 0
    {6'b111001, 8'd1,  5'b01000, 4'd3 },  // R3 code 1
    {6'b111001, 8'd20, 5'b10000, 4'd3 },  // R3 code 2
    {6'b111001, 8'd20, 5'b11000, 4'd10},  // R10 low during ramp
    {6'b111001, 8'd20, 5'b11000, 4'd3 },  // R3 complete
    {6'b111001, 8'd5,  5'b11000, 4'd10},  // R10 one edge early
    {6'b111001, 8'd1,  5'b11001, 4'd10},  // R10 rises
    {6'b111000, 8'd3,  5'b11001, 4'd11},  // R11 short excursion
    {6'b111001, 8'd2,  5'b11001, 4'd11},  // R11 ignored
    {6'b111000, 8'd5,  5'b11001, 4'd11},  // R11 one edge early
    {6'b111000, 8'd1,  5'b11000, 4'd11},  // R11 drops
    {6'b111001, 8'd5,  5'b11000, 4'd11},  // R11 recovery pending
    {6'b111001, 8'd1,  5'b11001, 4'd11}   // R11 recovered
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 1'b0, uvlo = 1'b0, en = 1'b0, ov = 1'b0, uv = 1'b0, win = 1'b0;
  logic [1:0] scale;
  logic fl, ts, pg;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rail_supervisor #(.STEP_CYC(STEP), .DEG_CYC(DEG), .BLANK_CYC(BLANK)) u_rail_supervisor (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_por_i  (por),
    .supply_uvlo_i (uvlo),
    .enable_i      (en),
    .ov_flag_i     (ov),
    .uv_flag_i     (uv),
    .in_window_i   (win),
    .ilim_scale_o  (scale),
    .force_low_o   (fl),
    .tristate_o    (ts),
    .pgood_o       (pg)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [1:0] e_sc, input logic e_fl, input logic e_ts,
                       input logic e_pg, input string tag);
    checks++;
    if ({scale, fl, ts, pg} !== {e_sc, e_fl, e_ts, e_pg}) begin
      errors++;
      $display("FAIL %s: {scale,force,tri,pg} actual=%b_%b%b%b expected=%b_%b%b%b",
               tag, scale, fl, ts, pg, e_sc, e_fl, e_ts, e_pg);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1 check(2'd0, 1'b0, 1'b0, 1'b0, "R1");  // in reset
    step(2);
    rst_n = 1'b1;
    step(1);
    check(2'd0, 1'b0, 1'b0, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      {por, uvlo, en, ov, uv, win} = VEC[i][22:17];
      step(int'(VEC[i][16:9]));
      check(VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));
    end

    // over-voltage: short pulse, then qualified latch
    ov = 1'b1; step(DEG - 1); ov = 1'b0; step(2);
    check(2'd3, 1'b0, 1'b0, 1'b1, "R5");
    ov = 1'b1; step(DEG);
    check(2'd3, 1'b0, 1'b0, 1'b1, "R5");
    step(1);
    check(2'd0, 1'b1, 1'b0, 1'b0, "R5");
    ov = 1'b0; uvlo = 1'b0; step(3);
    check(2'd0, 1'b1, 1'b0, 1'b0, "R8");
    uvlo = 1'b1; step(3);
    check(2'd0, 1'b1, 1'b0, 1'b0, "R8");

    // clear by enable, restart
    en = 1'b0; step(1);
    check(2'd0, 1'b0, 1'b0, 1'b0, "R8");
    en = 1'b1; step(1);  // E1
    check(2'd0, 1'b0, 1'b0, 1'b0, "R8");
    step(STEP);
    check(2'd1, 1'b0, 1'b0, 1'b0, "R8");

    // under-voltage with blanking (E1+20 now)
    uv = 1'b1; step(BLANK - 1 - STEP);  // E1+99
    check(2'd3, 1'b0, 1'b0, 1'b1, "R7");
    step(DEG + 1);  // E1+105
    check(2'd3, 1'b0, 1'b0, 1'b1, "R6");
    step(1);        // E1+106
    check(2'd0, 1'b0, 1'b1, 1'b0, "R6");
    uv = 1'b0; step(2);
    check(2'd0, 1'b0, 1'b1, 1'b0, "R8");
    por = 1'b0; step(1);
    check(2'd0, 1'b0, 1'b0, 1'b0, "R1");
    por = 1'b1; step(1);  // E2
    check(2'd0, 1'b0, 1'b0, 1'b0, "R1");

    // simultaneous faults
    step(BLANK);
    ov = 1'b1; uv = 1'b1; step(DEG);
    check(2'd3, 1'b0, 1'b0, 1'b1, "R9");
    step(1);
    check(2'd0, 1'b1, 1'b0, 1'b0, "R9");

    // lockout in mid-ramp
    ov = 1'b0; uv = 1'b0; en = 1'b0; step(1);
    en = 1'b1; step(1);  // E3
    step(STEP + 5);
    check(2'd1, 1'b0, 1'b0, 1'b0, "R4");
    uvlo = 1'b0; step(1);
    check(2'd0, 1'b1, 1'b0, 1'b0, "R4");
    uvlo = 1'b1; step(1);  // E4
    check(2'd0, 1'b0, 1'b0, 1'b0, "R4");
    step(STEP - 1);
    check(2'd0, 1'b0, 1'b0, 1'b0, "R4");
    step(1);
    check(2'd1, 1'b0, 1'b0, 1'b0, "R4");

    // asynchronous reset mid-run
    step(5);
    rst_n = 1'b0;
    #1 check(2'd0, 1'b0, 1'b0, 1'b0, "R1");
    step(1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule